// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps recently used address translations for a 32-bit virtual address space divided into 4 KB pages. A lookup presents a virtual address, and in the same cycle the block reports whether a cached page-level entry covers it and, if so, forms the physical address from the cached frame number and the unchanged page offset. It also reports whether a directory-level entry covering the enclosing 4 MB region is cached, so an external table walker that misses on the page entry can skip the first step of its walk.

Entries come in through a fill port driven by the walker. Each of the 16 sets holds 4 ways, and a fill either overwrites an entry that already maps the same key or takes a way chosen by an invalid-first rule and then a tree pseudo-LRU. A task-switch flush drops every entry whose global bit is clear. A full flush drops everything. The block does not walk tables, check permissions or raise faults.

Top module: `xlat_cache`

## Requirements
- R1: A synchronous reset clears every entry. In the cycle after reset is released, no lookup reports a page hit or a directory hit.
- R2: A page lookup uses set index vaddr[15:12] and tag vaddr[31:16]. It hits when that set holds a valid page-kind entry with an equal tag. On a hit, lk_paddr is {entry[31:12], vaddr[11:0]}. On a miss, lk_paddr is zero.
- R3: A directory lookup uses set index vaddr[25:22] and compares only vaddr[31:22] against the stored key. On a hit, lk_dir_pte returns the stored entry; on a miss it returns zero. A page-kind entry never gives a directory hit, and a directory-kind entry never gives a page hit.
- R4: A fill writes at the clock edge. A lookup of the filled page in the next cycle hits, with no memory access or wait.
- R5: A fill whose set already holds a valid entry of the same kind with the same key overwrites that way. For directories, the key is vaddr[31:22]. No duplicate is ever created.
- R6: Otherwise, a fill takes the lowest-numbered invalid way in its set.
- R7: When the set is full, the victim comes from three state bits per set, which reset to zero. Bit 0 = 0 selects ways 0/1 and bit 0 = 1 selects ways 2/3. Bit 1 gives the victim's low index bit within ways 0/1, and bit 2 gives it within ways 2/3. Using way w sets bit 0 to the inverse of w[1], and sets the bit of w's pair to the inverse of w[0]. Fills and page hits count as uses; directory hits do not. When a fill and a page hit fall in the same set in the same cycle, only the fill updates that set.
- R8: A task-switch flush invalidates every entry whose stored entry bit 8 (global) is 0, and keeps every entry with bit 8 = 1.
- R9: A full flush invalidates every entry, including global ones.
- R10: A fill in the same cycle as either flush leaves the filled way valid with the new contents.
- R11: With lk_valid low, no hit is reported, lk_paddr and lk_dir_pte are zero, and the replacement state is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_task | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Page-level entry hit |
| lk_paddr | output | 32 | Translated physical address, zero on miss |
| lk_dir_hit | output | 1 | Directory-level entry hit for the 4 MB region |
| lk_dir_pte | output | 32 | Cached directory entry, zero on miss |
| fill_en | input | 1 | Install an entry |
| fill_is_dir | input | 1 | 1: directory entry, 0: page entry |
| fill_vaddr | input | 32 | Virtual address the entry belongs to |
| fill_pte | input | 32 | Table entry contents to store |

## Verification
The properties assume the walker never fills while reset is high. They also assume that a lookup which should hit right after a fill is not made in the same cycle as a full flush that could clear the entry. The bench keeps a separate model of the 64 entries and of the three replacement bits per set, and it drives every control only between clock edges, one operation per cycle. Flushes combined with fills are issued only as deliberate single-cycle pairs whose outcome the model predicts.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [2:0] plru_t;

  // Victim way named by the tree bits.
  function automatic logic [WAY_W-1:0] plru_pick(input plru_t s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  // Point the tree away from a way that was just used.
  function automatic plru_t plru_mark(input plru_t s, input logic [WAY_W-1:0] w);
    plru_t n;
    n    = s;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/xlat_plru.sv
module xlat_plru
  import xlat_pkg::*;
#(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic [SET_W-1:0] q_set,
  input  logic [WAYS-1:0]  q_valid,
  output logic [WAY_W-1:0] q_victim
);
  localparam int SETS = 1 << SET_W;

  plru_t st_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      if (hit_en && !(fill_en && fill_set == hit_set))
        st_q[hit_set] <= plru_mark(st_q[hit_set], hit_way);
      if (fill_en)
        st_q[fill_set] <= plru_mark(st_q[fill_set], fill_way);
    end
  end

  // Lowest invalid way wins, otherwise the tree choice.
  always_comb begin
    q_victim = plru_pick(st_q[q_set]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!q_valid[w]) q_victim = WAY_W'(w);
  end
endmodule

// File: rtl/xlat_way_bank.sv
module xlat_way_bank #(
  parameter int SET_W   = 4,
  parameter int TAG_W   = 16,
  parameter int PTE_W   = 32,
  parameter int GLB_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_all,
  input  logic             flush_task,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic             wr_kind,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PTE_W-1:0] wr_pte,
  input  logic [SET_W-1:0] a_set,
  output logic             a_valid,
  output logic             a_kind,
  output logic [TAG_W-1:0] a_tag,
  output logic [PTE_W-1:0] a_pte,
  input  logic [SET_W-1:0] b_set,
  output logic             b_valid,
  output logic             b_kind,
  output logic [TAG_W-1:0] b_tag,
  output logic [PTE_W-1:0] b_pte,
  input  logic [SET_W-1:0] c_set,
  output logic             c_valid,
  output logic             c_kind,
  output logic [TAG_W-1:0] c_tag
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  valid_q;
  logic             kind_q [SETS];
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PTE_W-1:0] pte_q  [SETS];

  // Valid bits: the write comes last so it beats a flush.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++)
        if (flush_all || (flush_task && !pte_q[s][GLB_BIT])) valid_q[s] <= 1'b0;
      if (wr_en) valid_q[wr_set] <= 1'b1;
    end
  end

  // Payload: write-only storage without reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      kind_q[wr_set] <= wr_kind;
      tag_q[wr_set]  <= wr_tag;
      pte_q[wr_set]  <= wr_pte;
    end
  end

  assign a_valid = valid_q[a_set];
  assign a_kind  = kind_q[a_set];
  assign a_tag   = tag_q[a_set];
  assign a_pte   = pte_q[a_set];
  assign b_valid = valid_q[b_set];
  assign b_kind  = kind_q[b_set];
  assign b_tag   = tag_q[b_set];
  assign b_pte   = pte_q[b_set];
  assign c_valid = valid_q[c_set];
  assign c_kind  = kind_q[c_set];
  assign c_tag   = tag_q[c_set];
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int SET_W   = 4,
  parameter int DIR_W   = 10,
  parameter int PTE_W   = 32,
  parameter int GLB_BIT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush_task,
  input  logic            flush_all,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic            lk_hit,
  output logic [VA_W-1:0] lk_paddr,
  output logic            lk_dir_hit,
  output logic [PTE_W-1:0] lk_dir_pte,
  input  logic            fill_en,
  input  logic            fill_is_dir,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic [PTE_W-1:0] fill_pte
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int TAG_W  = VPN_W - SET_W;
  localparam int DIR_LO = VA_W - DIR_W;

  logic [SET_W-1:0] leaf_set, dir_set, f_set;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic [DIR_W-1:0] lk_dkey;

  assign leaf_set = lk_vaddr[OFF_W +: SET_W];
  assign dir_set  = lk_vaddr[DIR_LO +: SET_W];
  assign lk_tag   = lk_vaddr[VA_W-1 -: TAG_W];
  assign lk_dkey  = lk_vaddr[VA_W-1 -: DIR_W];
  assign f_set    = fill_is_dir ? fill_vaddr[DIR_LO +: SET_W] : fill_vaddr[OFF_W +: SET_W];
  assign f_tag    = fill_vaddr[VA_W-1 -: TAG_W];

  logic [WAYS-1:0]  a_valid, a_kind, b_valid, b_kind, c_valid, c_kind;
  logic [TAG_W-1:0] a_tag [WAYS];
  logic [TAG_W-1:0] b_tag [WAYS];
  logic [TAG_W-1:0] c_tag [WAYS];
  logic [PTE_W-1:0] a_pte [WAYS];
  logic [PTE_W-1:0] b_pte [WAYS];
  logic [WAYS-1:0]  leaf_match, dir_match, c_match;
  logic [WAY_W-1:0] victim, fill_way, hit_way;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
    xlat_way_bank #(
      .SET_W(SET_W), .TAG_W(TAG_W), .PTE_W(PTE_W), .GLB_BIT(GLB_BIT)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .flush_all (flush_all),
      .flush_task(flush_task),
      .wr_en     (fill_en && fill_way == WAY_W'(gw)),
      .wr_set    (f_set),
      .wr_kind   (fill_is_dir),
      .wr_tag    (f_tag),
      .wr_pte    (fill_pte),
      .a_set     (leaf_set),
      .a_valid   (a_valid[gw]),
      .a_kind    (a_kind[gw]),
      .a_tag     (a_tag[gw]),
      .a_pte     (a_pte[gw]),
      .b_set     (dir_set),
      .b_valid   (b_valid[gw]),
      .b_kind    (b_kind[gw]),
      .b_tag     (b_tag[gw]),
      .b_pte     (b_pte[gw]),
      .c_set     (f_set),
      .c_valid   (c_valid[gw]),
      .c_kind    (c_kind[gw]),
      .c_tag     (c_tag[gw])
    );

    assign leaf_match[gw] = lk_valid && a_valid[gw] && !a_kind[gw] && a_tag[gw] == lk_tag;
    assign dir_match[gw]  = lk_valid && b_valid[gw] && b_kind[gw] &&
                            b_tag[gw][TAG_W-1 -: DIR_W] == lk_dkey;
    assign c_match[gw]    = c_valid[gw] && (c_kind[gw] == fill_is_dir) &&
                            (fill_is_dir ? c_tag[gw][TAG_W-1 -: DIR_W] == f_tag[TAG_W-1 -: DIR_W]
                                         : c_tag[gw] == f_tag);
  end

  xlat_plru #(.SET_W(SET_W)) u_plru (
    .clk     (clk),
    .rst     (rst),
    .fill_en (fill_en),
    .fill_set(f_set),
    .fill_way(fill_way),
    .hit_en  (lk_hit),
    .hit_set (leaf_set),
    .hit_way (hit_way),
    .q_set   (f_set),
    .q_valid (c_valid),
    .q_victim(victim)
  );

  always_comb begin
    fill_way = victim;
    for (int w = 0; w < WAYS; w++)
      if (c_match[w]) fill_way = WAY_W'(w);
  end

  always_comb begin
    lk_hit     = |leaf_match;
    lk_dir_hit = |dir_match;
    lk_paddr   = '0;
    lk_dir_pte = '0;
    hit_way    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (leaf_match[w]) begin
        lk_paddr = {a_pte[w][PTE_W-1 -: VPN_W], lk_vaddr[OFF_W-1:0]};
        hit_way  = WAY_W'(w);
      end
      if (dir_match[w]) lk_dir_pte = b_pte[w];
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int WAYS  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            flush_all,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_hit,
  input logic [VA_W-1:0] lk_paddr,
  input logic            lk_dir_hit,
  input logic            fill_en,
  input logic            fill_is_dir,
  input logic [VA_W-1:0] fill_vaddr,
  input logic [WAYS-1:0] leaf_match
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !lk_hit && !lk_dir_hit);

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_paddr == '0);

  // R4
  fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !$past(rst) && $past(fill_en && !fill_is_dir && !flush_all) &&
     lk_vaddr[VA_W-1:OFF_W] == $past(fill_vaddr[VA_W-1:OFF_W])) |-> lk_hit);

  // R5
  no_dup_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(leaf_match));

  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !fill_en) |=> !lk_hit && !lk_dir_hit);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !lk_hit && !lk_dir_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .WAYS(xlat_pkg::WAYS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush_all  (flush_all),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_hit     (lk_hit),
  .lk_paddr   (lk_paddr),
  .lk_dir_hit (lk_dir_hit),
  .fill_en    (fill_en),
  .fill_is_dir(fill_is_dir),
  .fill_vaddr (fill_vaddr),
  .leaf_match (leaf_match)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, flush_task, flush_all, lk_valid, fill_en, fill_is_dir;
  logic [31:0] lk_vaddr, fill_vaddr, fill_pte, lk_dir_pte, lk_paddr;
  logic        lk_hit, lk_dir_hit;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst(rst), .flush_task(flush_task), .flush_all(flush_all),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_dir_hit(lk_dir_hit), .lk_dir_pte(lk_dir_pte),
    .fill_en(fill_en), .fill_is_dir(fill_is_dir), .fill_vaddr(fill_vaddr), .fill_pte(fill_pte)
  );

  // Reference model
  bit          m_v [16][4];
  bit          m_k [16][4];
  logic [15:0] m_t [16][4];
  logic [31:0] m_p [16][4];
  logic [2:0]  m_s [16];

  function automatic int m_pick(input int s);
    if (m_s[s][0]) return 2 + int'(m_s[s][2]);
    return int'(m_s[s][1]);
  endfunction

  task automatic m_touch(input int s, input int w);
    m_s[s][0] = (w < 2);
    if (w < 2) m_s[s][1] = (w == 0);
    else       m_s[s][2] = (w == 2);
  endtask

  task automatic m_reset();
    for (int s = 0; s < 16; s++) begin
      m_s[s] = '0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
    end
  endtask

  task automatic m_fill_way(input logic [31:0] va, input bit dir, output int s, output int way);
    s = dir ? int'(va[25:22]) : int'(va[15:12]);
    way = -1;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_k[s][w] == dir &&
          (dir ? m_t[s][w][15:6] == va[31:22] : m_t[s][w] == va[31:16])) way = w;
    if (way < 0)
      for (int w = 3; w >= 0; w--) if (!m_v[s][w]) way = w;
    if (way < 0) way = m_pick(s);
  endtask

  task automatic m_write(input int s, input int w, input logic [31:0] va, input bit dir,
                         input logic [31:0] pte);
    m_v[s][w] = 1'b1; m_k[s][w] = dir; m_t[s][w] = va[31:16]; m_p[s][w] = pte;
    m_touch(s, w);
  endtask

  task automatic m_leaf(input logic [31:0] va, output bit hit, output int way,
                        output logic [31:0] pa);
    int s;
    s = int'(va[15:12]); hit = 0; way = 0; pa = '0;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && !m_k[s][w] && m_t[s][w] == va[31:16]) begin
        hit = 1; way = w; pa = {m_p[s][w][31:12], va[11:0]};
      end
  endtask

  task automatic m_dir(input logic [31:0] va, output bit hit, output logic [31:0] pte);
    int s;
    s = int'(va[25:22]); hit = 0; pte = '0;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_k[s][w] && m_t[s][w][15:6] == va[31:22]) begin
        hit = 1; pte = m_p[s][w];
      end
  endtask

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_va(input int s, input int i);
    logic [15:0] t;
    t = 16'(32'h1000 + i * 257 + s * 17);
    return {t, 4'(s), 12'(32'h5A0 + i * 3)};
  endfunction

  function automatic logic [31:0] mk_pte(input int s, input int i, input bit gl);
    return {20'(32'h40000 + s * 64 + i), 3'b000, gl, 8'h01};
  endfunction

  task automatic compare_look(input logic [31:0] va, input string r,
                              output bit eh, output int ew);
    logic [31:0] epa, edp;
    bit edh;
    m_leaf(va, eh, ew, epa);
    m_dir(va, edh, edp);
    chk(lk_hit == eh, r, {31'b0, lk_hit}, {31'b0, eh});
    chk(lk_paddr == epa, r, lk_paddr, epa);
    chk(lk_dir_hit == edh, r, {31'b0, lk_dir_hit}, {31'b0, edh});
    chk(lk_dir_pte == edp, r, lk_dir_pte, edp);
  endtask

  task automatic look(input logic [31:0] va, input string r);
    bit eh; int ew;
    lk_valid = 1'b1; lk_vaddr = va;
    #1;
    compare_look(va, r, eh, ew);
    @(posedge clk);
    if (eh) m_touch(int'(va[15:12]), ew);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic idle_look(input logic [31:0] va);
    lk_valid = 1'b0; lk_vaddr = va;
    #1;
    chk(!lk_hit && !lk_dir_hit, "R11", {30'b0, lk_hit, lk_dir_hit}, 32'h0);
    chk(lk_paddr == 0 && lk_dir_pte == 0, "R11", lk_paddr | lk_dir_pte, 32'h0);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic [31:0] va, input bit dir, input logic [31:0] pte);
    int s, w;
    fill_en = 1'b1; fill_is_dir = dir; fill_vaddr = va; fill_pte = pte;
    m_fill_way(va, dir, s, w);
    @(posedge clk);
    m_write(s, w, va, dir, pte);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic m_flush(input bit all);
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        if (all || !m_p[s][w][8]) m_v[s][w] = 1'b0;
  endtask

  task automatic flush(input bit all, input bit with_fill, input logic [31:0] va,
                       input logic [31:0] pte);
    int s, w;
    flush_all = all; flush_task = !all;
    fill_en = with_fill; fill_is_dir = 1'b0; fill_vaddr = va; fill_pte = pte;
    m_fill_way(va, 1'b0, s, w);
    @(posedge clk);
    m_flush(all);
    if (with_fill) m_write(s, w, va, 1'b0, pte);
    @(negedge clk);
    flush_all = 1'b0; flush_task = 1'b0; fill_en = 1'b0;
  endtask

  task automatic look_fill(input logic [31:0] lva, input logic [31:0] fva, input logic [31:0] pte);
    int fs, fw, ew;
    bit eh;
    lk_valid = 1'b1; lk_vaddr = lva;
    fill_en = 1'b1; fill_is_dir = 1'b0; fill_vaddr = fva; fill_pte = pte;
    #1;
    compare_look(lva, "R7", eh, ew);
    m_fill_way(fva, 1'b0, fs, fw);
    @(posedge clk);
    if (eh && int'(lva[15:12]) != fs) m_touch(int'(lva[15:12]), ew);
    m_write(fs, fw, fva, 1'b0, pte);
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst = 1'b1; flush_task = 0; flush_all = 0; lk_valid = 0; fill_en = 0; fill_is_dir = 0;
    lk_vaddr = '0; fill_vaddr = '0; fill_pte = '0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R4 then R1: fill, see it, reset, see it gone
    fill(mk_va(3, 0), 1'b0, mk_pte(3, 0, 1'b0));
    fill(mk_va(7, 1), 1'b0, mk_pte(7, 1, 1'b1));
    look(mk_va(3, 0), "R4");
    look(mk_va(7, 1), "R4");
    rst = 1'b1;
    @(posedge clk);
    m_reset();
    @(negedge clk);
    rst = 1'b0;
    look(mk_va(3, 0), "R1");
    look(mk_va(7, 1), "R1");

    // R2 / R6: fill every way of every set, then look up all of them
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 4; i++) begin
        fill(mk_va(s, i), 1'b0, mk_pte(s, i, i[0]));
        if (s == 0 && i == 1) look(mk_va(0, 0), "R6");
      end
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 5; i++) look(mk_va(s, i), "R2");

    // R7 with R11: reorder use, then force an eviction in each set
    for (int s = 0; s < 16; s++) begin
      look(mk_va(s, s % 4), "R7");
      if (s[0]) idle_look(mk_va(s, (s + 1) % 4));
      fill(mk_va(s, 4), 1'b0, mk_pte(s, 4, 1'b0));
      for (int i = 0; i < 5; i++) look(mk_va(s, i), "R7");
    end
    look_fill(mk_va(2, 1), mk_va(2, 5), mk_pte(2, 5, 1'b1));
    look_fill(mk_va(4, 4), mk_va(9, 5), mk_pte(9, 5, 1'b0));
    for (int i = 0; i < 6; i++) begin
      look(mk_va(2, i), "R7");
      look(mk_va(9, i), "R7");
    end

    // R5: refill a resident page with new contents
    fill(mk_va(6, 4), 1'b0, mk_pte(6, 4, 1'b0) ^ 32'h0010_0000);
    for (int i = 0; i < 6; i++) look(mk_va(6, i), "R5");

    // R8: task flush keeps global entries; R6 after holes open up
    flush(1'b0, 1'b0, '0, '0);
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 6; i++) look(mk_va(s, i), "R8");
    fill(mk_va(0, 6), 1'b0, mk_pte(0, 6, 1'b0));
    for (int i = 0; i < 7; i++) look(mk_va(0, i), "R6");

    // R3: directory entries cover a 4 MB region
    fill(32'hA940_0000, 1'b1, 32'h1234_5107);
    for (int k = 0; k < 8; k++) look(32'hA940_0000 + k * 32'h0005_1234, "R3");
    look(32'hA980_0123, "R3");
    fill(32'hA940_3000, 1'b0, 32'h7777_7001);
    look(32'hA940_3ABC, "R3");
    fill(32'hA95F_F000, 1'b1, 32'h2468_A003);
    look(32'hA941_0000, "R5");
    look(32'hA940_3004, "R3");

    // R10: fill racing each flush kind
    flush(1'b1, 1'b1, mk_va(10, 7), mk_pte(10, 7, 1'b0));
    look(mk_va(10, 7), "R10");
    look(mk_va(11, 1), "R10");
    fill(mk_va(12, 1), 1'b0, mk_pte(12, 1, 1'b0));
    flush(1'b0, 1'b1, mk_va(13, 2), mk_pte(13, 2, 1'b0));
    look(mk_va(13, 2), "R10");
    look(mk_va(12, 1), "R10");

    // R9: full flush drops global entries too
    fill(mk_va(5, 3), 1'b0, mk_pte(5, 3, 1'b1));
    fill(32'h1230_0000, 1'b1, 32'h0000_0101);
    look(mk_va(5, 3), "R9");
    flush(1'b1, 1'b0, '0, '0);
    look(mk_va(5, 3), "R9");
    look(32'h1230_0000, "R9");
    look(mk_va(10, 7), "R9");

    finish_up();
  end
endmodule